// File: doc/BRIEF.md
# Background SPI ADC Stream Receiver

This block reads samples from an SPI-style analog-to-digital converter without help from the host. After it is enabled, it makes a serial clock from the system clock through a programmable divider. It runs chip-select frames of a programmable number of serial clocks, one after another. Each frame ends with one idle serial-clock period with chip-select high. Received bits go into a shift register. When a frame completes, the whole word is copied into a result register and a one-cycle strobe is raised.

An optional channel-select output changes level once per frame, so a dual or interleaved converter can alternate between its inputs. The host changes settings with a single 32-bit write. The write is accepted only when bit 31 is set. Reads share a port with an existing counter value. While streaming is enabled the read port returns the latest sample. While streaming is disabled it returns the counter value unchanged.

Top module: `spi_adc_stream`

## Requirements
- R1: While enabled, with divider field N in config bits [9:2], `adc_sclk` is a square wave with a period of 2*(N+1) system clocks that starts low. N = 0 gives a period of 2 clocks.
- R2: With length field M in config bits [14:10], the frame length is L = M+1 serial clocks (1 to 32). `adc_cs_n` stays low for exactly L*2*(N+1) system clocks, then stays high for one serial-clock period, and this repeats.
- R3: `adc_miso` is sampled on each rising `adc_sclk` while `adc_cs_n` is low. The first bit becomes the most significant of the L-bit sample. The sample sits in the low L bits of the result and the upper bits are zero.
- R4: The result register changes only at a frame end. At the same edge `sample_valid` goes high for exactly one cycle. Frame ends are spaced (L+1)*2*(N+1) clocks apart.
- R5: When config bit [1] is set, `adc_chsel` changes level at every frame end. When bit [1] is clear, `adc_chsel` stays 0.
- R6: A write with `cfg_wdata[31]` clear changes nothing. A write with it set loads all fields and restarts the serial engine from the start of a frame.
- R7: `rd_data` returns the result register when config bit [0] (enable) is set, and returns `ctr_value` when it is clear.
- R8: Clearing the enable bit forces `adc_sclk` low and `adc_cs_n` high by the next clock edge. No further `sample_valid` is produced while disabled.
- R9: If a configuration write falls on the same edge as a frame end, the write takes priority. That frame is discarded, no `sample_valid` is raised, and the previous result is kept.
- R10: After reset the block is disabled, `adc_sclk` and `adc_chsel` are 0, `adc_cs_n` is 1, `sample_valid` is 0, and `rd_data` follows `ctr_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word; bit 31 marks a valid serial configuration |
| ctr_value | input | 32 | Counter value shown on the read port while streaming is off |
| adc_miso | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_chsel | output | 1 | Channel select, changes level once per frame |
| rd_data | output | 32 | Latest sample or counter value |
| sample_valid | output | 1 | One-cycle pulse when a new sample is stored |

## Verification
The two functions that can land on the same edge are a host configuration write and the completion of a frame. The bench measures the frame-end spacing from one observed strobe. It then times a write so that it reaches the clock edge on which the next strobe would fire. It passes only if that edge produces no strobe and the read port still shows the previous sample. A converter model in the bench shifts random words out MSB first on falling serial clocks, and each stored sample is compared against the word that was sent.

// File: rtl/spi_adc_stream_pkg.sv
// Package: shared widths and the configuration record for the SPI ADC
// stream receiver. Assumes a 32-bit configuration word with bit 31 as the
// serial-configuration flag.
package spi_adc_stream_pkg;
    localparam int SAS_DIV_W  = 8;
    localparam int SAS_LEN_W  = 5;
    localparam int SAS_DATA_W = 1 << SAS_LEN_W;
    localparam int SAS_CNT_W  = SAS_LEN_W + 1;

    // Bit positions inside the configuration word
    localparam int SAS_FLAG_BIT = 31;
    localparam int SAS_EN_BIT   = 0;
    localparam int SAS_SEL_BIT  = 1;
    localparam int SAS_DIV_LSB  = 2;
    localparam int SAS_LEN_LSB  = SAS_DIV_LSB + SAS_DIV_W;

    typedef struct packed {
        logic                 en;
        logic                 sel_en;
        logic [SAS_DIV_W-1:0] div_n;
        logic [SAS_LEN_W-1:0] len_m1;
    } sas_cfg_t;
endpackage

// File: rtl/sas_cfg_reg.sv
// Configuration register: holds the serial settings. It loads only on a write
// whose flag bit is set and also raises a restart pulse for the engine.
// Assumes cfg_wdata is stable while cfg_we is high.
module sas_cfg_reg
    import spi_adc_stream_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output sas_cfg_t    cfg,
    output logic        restart
);
    logic accept;
    assign accept  = cfg_we && cfg_wdata[SAS_FLAG_BIT];
    assign restart = accept;

    // Load all fields on an accepted write; the default length is 16 clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.en     <= 1'b0;
            cfg.sel_en <= 1'b0;
            cfg.div_n  <= '0;
            cfg.len_m1 <= SAS_LEN_W'(15);
        end else if (accept) begin
            cfg.en     <= cfg_wdata[SAS_EN_BIT];
            cfg.sel_en <= cfg_wdata[SAS_SEL_BIT];
            cfg.div_n  <= cfg_wdata[SAS_DIV_LSB +: SAS_DIV_W];
            cfg.len_m1 <= cfg_wdata[SAS_LEN_LSB +: SAS_LEN_W];
        end
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_wdata[SAS_FLAG_BIT]) |=> $stable(cfg));
endmodule

// File: rtl/sas_clkgen.sv
// Serial clock generator: a divider counts 0..div_n and the serial clock
// flips at each terminal count, so one period is 2*(div_n+1) system clocks.
// Gives one-cycle rise and fall ticks that line up with the edges of the
// sclk register. Assumes a restart is asserted whenever div_n changes.
module sas_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_n,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick      = en && !restart && (cnt == div_n);
    assign rise_tick = tick && !sclk;
    assign fall_tick = tick && sclk;

    // Divider count and serial clock flip, idle low while off or restarting
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == div_n) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R1
    div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt <= div_n);
endmodule

// File: rtl/sas_frame.sv
// Frame engine: counts serial clocks inside a frame, shifts data in MSB
// first on rising ticks, and copies the word to the result at the frame end
// along with a one-cycle valid pulse. The slot after the last bit is the
// idle gap with chip-select high. Assumes the ticks come from sas_clkgen.
module sas_frame #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sel_en,
    input  logic              restart,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              miso,
    output logic              cs_n,
    output logic              chsel,
    output logic              valid,
    output logic [DATA_W-1:0] result
);
    localparam int CNT_W = LEN_W + 1;

    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  frame_len;
    logic [DATA_W-1:0] shreg;
    logic              sel_q;
    logic              in_frame;
    logic              last_bit;

    assign frame_len = {1'b0, len_m1} + 1'b1;
    assign in_frame  = en && (bit_cnt < frame_len);
    assign last_bit  = (bit_cnt == CNT_W'(len_m1));
    assign cs_n      = !in_frame;
    assign chsel     = sel_q && sel_en;

    // Bit position and shift register, cleared at a frame start and on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            if (rise_tick && in_frame)
                shreg <= {shreg[DATA_W-2:0], miso};
            if (fall_tick) begin
                if (bit_cnt == frame_len) begin
                    bit_cnt <= '0;
                    shreg   <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Result, valid pulse and channel select updated together at a frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!restart && en && fall_tick && last_bit) begin
                result <= shreg;
                valid  <= 1'b1;
                if (sel_en)
                    sel_q <= ~sel_q;
            end
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= frame_len);
    // R4
    valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !$past(cs_n));
    // R5
    sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sel_en) |-> (chsel != $past(chsel)));
    // R9
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !valid);
endmodule

// File: rtl/spi_adc_stream.sv
// Top: background SPI ADC stream receiver. Puts together the config register,
// the serial clock generator and the frame engine, and picks either the
// latest sample or the counter value for the read port. Assumes the converter
// changes its data after the falling serial clock.
module spi_adc_stream
    import spi_adc_stream_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] ctr_value,
    input  logic        adc_miso,
    output logic        adc_sclk,
    output logic        adc_cs_n,
    output logic        adc_chsel,
    output logic [31:0] rd_data,
    output logic        sample_valid
);
    sas_cfg_t                cfg;
    logic                    restart;
    logic                    rise_tick;
    logic                    fall_tick;
    logic [SAS_DATA_W-1:0]   result;

    sas_cfg_reg cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .restart   (restart)
    );

    sas_clkgen #(.DIV_W(SAS_DIV_W)) clk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.en),
        .restart   (restart),
        .div_n     (cfg.div_n),
        .sclk      (adc_sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sas_frame #(.DATA_W(SAS_DATA_W), .LEN_W(SAS_LEN_W)) frm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.en),
        .sel_en    (cfg.sel_en),
        .restart   (restart),
        .len_m1    (cfg.len_m1),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .miso      (adc_miso),
        .cs_n      (adc_cs_n),
        .chsel     (adc_chsel),
        .valid     (sample_valid),
        .result    (result)
    );

    // Read port: sample while streaming, counter value otherwise
    always_comb begin
        rd_data = ctr_value;
        if (cfg.en)
            rd_data = 32'(result);
    end

    // R8
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> (!adc_sclk && adc_cs_n && !sample_valid));
endmodule

// File: tb/spi_adc_stream_tb.sv
// Bench: random and directed configurations. A converter model shifts out
// random words, and periods, widths, samples and channel select are checked.
module spi_adc_stream_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] ctr_value;
    logic        adc_miso;
    logic        adc_sclk;
    logic        adc_cs_n;
    logic        adc_chsel;
    logic [31:0] rd_data;
    logic        sample_valid;

    int total = 0;
    int bad   = 0;
    int wd    = 0;
    int cyc   = 0;

    int  cur_n = 0, cur_l = 16;
    bit  cur_sel = 0;
    bit  mon_on = 0;
    int  vcount = 0;
    int  last_rise = -1;
    int  low_cnt = 0;
    int  idx = 0;
    logic [31:0] cur_word = '0;
    logic [31:0] last_exp = '0;
    logic prev_sclk = 0, prev_cs = 1, prev_valid = 0, prev_sel = 0;

    always #2 clk = ~clk;   // 250 MHz

    spi_adc_stream dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctr_value(ctr_value), .adc_miso(adc_miso), .adc_sclk(adc_sclk),
        .adc_cs_n(adc_cs_n), .adc_chsel(adc_chsel), .rd_data(rd_data),
        .sample_valid(sample_valid)
    );

    function automatic logic [31:0] mask_of(input int l);
        return (l >= 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 32'd1);
    endfunction

    function automatic logic [31:0] cfg_word(input int n, input int l, input bit sel, input bit en);
        logic [31:0] w = 32'h8000_0000;
        w[0]     = en;
        w[1]     = sel;
        w[9:2]   = 8'(n);
        w[14:10] = 5'(l - 1);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Monitor and converter model
    always @(negedge clk) begin
        cyc++;
        if (!mon_on) begin
            last_rise = -1;
            low_cnt   = 0;
        end else begin
            if (sample_valid) begin
                // R3 R4: sample equals the sent word masked to L bits
                check(rd_data == (cur_word & mask_of(cur_l)), "R3", rd_data, cur_word & mask_of(cur_l));
                last_exp = cur_word & mask_of(cur_l);
                // R4: single-cycle pulse
                check(!prev_valid, "R4", 32'(prev_valid), 0);
                // R5
                if (cur_sel) check(adc_chsel != prev_sel, "R5", 32'(adc_chsel), 32'(!prev_sel));
                else         check(adc_chsel == 1'b0, "R5", 32'(adc_chsel), 0);
                vcount++;
            end
            if (adc_sclk && !prev_sclk) begin
                // R1
                if (last_rise >= 0)
                    check(cyc - last_rise == 2 * (cur_n + 1), "R1", cyc - last_rise, 2 * (cur_n + 1));
                last_rise = cyc;
            end
            if (!adc_cs_n) low_cnt++;
            if (adc_cs_n && !prev_cs) begin
                // R2
                check(low_cnt == cur_l * 2 * (cur_n + 1), "R2", low_cnt, cur_l * 2 * (cur_n + 1));
                low_cnt = 0;
            end
            if (!adc_cs_n && prev_cs) begin
                cur_word = $urandom;
                idx      = cur_l - 1;
                adc_miso = cur_word[idx];
            end else if (!adc_sclk && prev_sclk && !adc_cs_n) begin
                idx--;
                if (idx >= 0) adc_miso = cur_word[idx];
            end
        end
        prev_sclk  = adc_sclk;
        prev_cs    = adc_cs_n;
        prev_valid = sample_valid;
        prev_sel   = adc_chsel;
    end

    task automatic run_cfg(input int n, input int l, input bit sel, input int frames);
        mon_on = 0;
        cfg_write(32'h8000_0000);
        repeat (3) @(negedge clk);
        cur_n = n; cur_l = l; cur_sel = sel; vcount = 0;
        ctr_value = $urandom;
        mon_on = 1;
        cfg_write(cfg_word(n, l, sel, 1'b1));
        while (vcount < frames) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; adc_miso = 1'b0;
        ctr_value = 32'hC0DE_1234;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        check(!adc_sclk && adc_cs_n && !sample_valid && !adc_chsel, "R10",
              {28'd0, adc_sclk, adc_cs_n, sample_valid, adc_chsel}, 32'h4);
        check(rd_data == ctr_value, "R10", rd_data, ctr_value);

        // R6: write without the flag is ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'h0000_0003;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (30) @(negedge clk);
        check(adc_cs_n && !adc_sclk, "R6", {30'd0, adc_cs_n, adc_sclk}, 32'h2);
        check(rd_data == ctr_value, "R6", rd_data, ctr_value);

        // Directed corners
        run_cfg(0, 16, 1'b1, 4);
        run_cfg(0, 1, 1'b0, 4);
        run_cfg(3, 32, 1'b1, 3);
        run_cfg(2, 7, 1'b0, 3);
        // Random configurations
        for (int k = 0; k < 10; k++)
            run_cfg($urandom_range(0, 4), $urandom_range(1, 32), 1'($urandom_range(0, 1)), 3);

        // R8: disable stops the clock and releases chip select
        mon_on = 0;
        cfg_write(32'h8000_0000);
        check(!adc_sclk && adc_cs_n, "R8", {30'd0, adc_sclk, adc_cs_n}, 32'h1);
        repeat (40) begin
            @(negedge clk);
            if (sample_valid || adc_sclk || !adc_cs_n)
                check(1'b0, "R8", {29'd0, sample_valid, adc_sclk, adc_cs_n}, 32'h1);
        end
        total++;
        // R7: counter value on read port while off
        ctr_value = 32'h1357_9BDF;
        @(negedge clk);
        check(rd_data == 32'h1357_9BDF, "R7", rd_data, 32'h1357_9BDF);

        // R9: configuration write on a frame-end edge
        run_cfg(1, 4, 1'b1, 2);
        do @(negedge clk); while (!sample_valid);
        repeat ((4 + 1) * 2 * (1 + 1) - 1) @(negedge clk);
        mon_on = 0;
        cfg_we = 1'b1; cfg_wdata = cfg_word(1, 4, 1'b1, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0;
        check(!sample_valid, "R9", 32'(sample_valid), 0);
        check(rd_data == last_exp, "R9", rd_data, last_exp);
        // R7: read port shows the sample, not the counter, while on
        check(rd_data != ctr_value || last_exp == ctr_value, "R7", rd_data, last_exp);
        cfg_write(32'h8000_0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule